// File: doc/BRIEF.md
# Speculative Commit-Rollback State Unit

This block keeps the architectural state of a processor that runs translated code speculatively. Each architectural register exists twice: a working copy, which takes ordinary instruction writes, and a committed shadow copy, which holds the value as of the last commit point. Stores are not sent to memory when they execute. They wait in a gated store buffer, and loads snoop that buffer so that they see their own block's stores.

A single commit pulse, issued at the end of a translated block, makes the speculative work permanent. It copies every working register into its shadow and releases all waiting stores to drain toward memory. A single rollback pulse, issued on an exception, reloads every working register from its shadow and discards every store that has not been released. The trap therefore sees exactly the state of the last commit point. Released stores leave in program order through a valid/ready handshake.

Top module: `spec_state_unit`

## Requirements
- R1: After reset every working and shadow register reads as zero, the store buffer is empty, `mem_valid`, `sb_full` and `ld_hit` are low.
- R2: A write with `wr_low8`=0 replaces all 32 bits of the working register named by `wr_addr`; the new value is readable on `rd_data` from the next cycle, and the shadow copy keeps its old value.
- R3: A write with `wr_low8`=1 replaces only bits 7:0 of the working register and leaves bits 31:8 unchanged.
- R4: An enqueued store never appears on the memory port before a commit.
- R5: A load whose `ld_addr` equals the full address of one or more buffered, undrained stores raises `ld_hit`, and `ld_data` is `ld_mem_data` with the bytes of each matching store laid over it from oldest to youngest (byte k is bits 8k+7:8k, enabled by `st_be[k]`), so the youngest store wins. With no full match `ld_hit` is 0 and `ld_data` equals `ld_mem_data`.
- R6: A commit copies each working register into its shadow, including a write made in the same cycle, and releases every buffered store, including one enqueued in the same cycle; `mem_valid` rises in the cycle after the commit.
- R7: A rollback reloads every working register from its shadow in one cycle, discards a write made in the same cycle, and drops every unreleased store so that later loads no longer hit on it.
- R8: Released stores leave one per cycle in enqueue order; while `mem_valid` is high and `mem_ready` low the memory outputs hold steady, and a rollback does not remove released stores.
- R9: `sb_full` is high while the buffer holds SB_DEPTH entries, released or not; a store offered while full is dropped and `st_err` is high in that cycle.
- R10: When commit and rollback are both high in one cycle, the rollback takes effect and the commit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | $clog2(NUM_REGS) | Register read index |
| rd_data | output | 32 | Working value of the read register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NUM_REGS) | Register write index |
| wr_data | input | 32 | Register write value |
| wr_low8 | input | 1 | Write only bits 7:0 |
| st_valid | input | 1 | Store enqueue strobe |
| st_addr | input | ADDR_W | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| sb_full | output | 1 | Buffer holds SB_DEPTH entries |
| st_err | output | 1 | Store offered while full |
| ld_addr | input | ADDR_W | Load snoop address |
| ld_mem_data | input | 32 | Data read from memory for the load |
| ld_hit | output | 1 | Load matched a buffered store |
| ld_data | output | 32 | Merged load data |
| commit | input | 1 | Commit pulse |
| rollback | input | 1 | Rollback pulse |
| mem_valid | output | 1 | Released store available |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | ADDR_W | Drained store address |
| mem_data | output | 32 | Drained store data |
| mem_be | output | 4 | Drained store byte enables |

## Verification
The hardest state to reach is a buffer that holds released stores stalled on the memory port and fresh unreleased stores behind them when a rollback arrives, because the rollback must cut the queue exactly at the release boundary. The bench holds `mem_ready` low through a commit, enqueues further stores, and then pulses rollback. It then snoops both groups of addresses and lets the queue drain to confirm order and survival. Same-cycle write-with-commit, write-with-rollback and commit-with-rollback are each driven directly to cover the cycle-level priority.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTES_W = DATA_W / 8;

  // Overlay enabled bytes of a store onto a base word
  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0]  base,
    input logic [DATA_W-1:0]  data,
    input logic [BYTES_W-1:0] be
  );
    logic [DATA_W-1:0] r;
    r = base;
    for (int b = 0; b < BYTES_W; b++) begin
      if (be[b]) r[b*8 +: 8] = data[b*8 +: 8];
    end
    return r;
  endfunction

  // Register update: full word or low byte only
  function automatic logic [DATA_W-1:0] reg_update(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic              low8
  );
    return low8 ? {old_v[DATA_W-1:8], new_v[7:0]} : new_v;
  endfunction
endpackage

// File: rtl/ssu_regfile.sv
module ssu_regfile
  import ssu_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int RIW = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIW-1:0]    rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [RIW-1:0]    wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_low8,
  input  logic              do_commit,
  input  logic              do_rollback
);
  logic [DATA_W-1:0] work_q [NUM_REGS];
  logic [DATA_W-1:0] shad_q [NUM_REGS];
  logic [DATA_W-1:0] work_n [NUM_REGS];

  assign rd_data = work_q[rd_addr];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit_w;
    assign hit_w = wr_en && (wr_addr == RIW'(i));

    always_comb begin
      work_n[i] = hit_w ? reg_update(work_q[i], wr_data, wr_low8) : work_q[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        work_q[i] <= '0;
        shad_q[i] <= '0;
      end else if (do_rollback) begin
        work_q[i] <= shad_q[i];
      end else begin
        work_q[i] <= work_n[i];
        if (do_commit) shad_q[i] <= work_n[i];
      end
    end

    AST_RB_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      do_rollback |=> work_q[i] == $past(shad_q[i])); // R7
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!do_commit || do_rollback) |=> $stable(shad_q[i])); // R2
    AST_LOW8_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_w && wr_low8 && !do_rollback) |=>
        work_q[i][DATA_W-1:8] == $past(work_q[i][DATA_W-1:8])); // R3
  end
endmodule

// File: rtl/ssu_store_buf.sv
module ssu_store_buf
  import ssu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SB_DEPTH = 4,
  localparam int PW = $clog2(SB_DEPTH),
  localparam int CW = PW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [DATA_W-1:0]  st_data,
  input  logic [BYTES_W-1:0] st_be,
  output logic               sb_full,
  output logic               st_err,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0]  ld_mem_data,
  output logic               ld_hit,
  output logic [DATA_W-1:0]  ld_data,
  input  logic               do_commit,
  input  logic               do_rollback,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_data,
  output logic [BYTES_W-1:0] mem_be
);
  logic [ADDR_W-1:0]  ent_addr [SB_DEPTH];
  logic [DATA_W-1:0]  ent_data [SB_DEPTH];
  logic [BYTES_W-1:0] ent_be   [SB_DEPTH];

  logic [PW-1:0] head_q;
  logic [CW-1:0] n_rel_q, n_pend_q, n_rel_n, n_pend_n, occ;
  logic [PW-1:0] tail;
  logic          enq_ok, drain_fire;

  assign occ        = n_rel_q + n_pend_q;
  assign tail       = head_q + PW'(occ);
  assign sb_full    = (occ == CW'(SB_DEPTH));
  assign st_err     = st_valid && sb_full;
  assign enq_ok     = st_valid && !sb_full;
  assign mem_valid  = (n_rel_q != '0);
  assign drain_fire = mem_valid && mem_ready;
  assign mem_addr   = ent_addr[head_q];
  assign mem_data   = ent_data[head_q];
  assign mem_be     = ent_be[head_q];

  always_comb begin
    n_rel_n  = n_rel_q - CW'(drain_fire);
    n_pend_n = n_pend_q;
    if (do_rollback) begin
      n_pend_n = '0;
    end else if (do_commit) begin
      n_rel_n  = n_rel_n + n_pend_q + CW'(enq_ok);
      n_pend_n = '0;
    end else begin
      n_pend_n = n_pend_q + CW'(enq_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      n_rel_q  <= '0;
      n_pend_q <= '0;
    end else begin
      if (drain_fire) head_q <= head_q + 1'b1;
      n_rel_q  <= n_rel_n;
      n_pend_q <= n_pend_n;
    end
  end

  always_ff @(posedge clk) begin
    if (enq_ok && !do_rollback) begin
      ent_addr[tail] <= st_addr;
      ent_data[tail] <= st_data;
      ent_be[tail]   <= st_be;
    end
  end

  // Snoop: walk oldest to youngest so the youngest match lands last
  always_comb begin
    logic [PW-1:0] idx;
    ld_data = ld_mem_data;
    ld_hit  = 1'b0;
    for (int i = 0; i < SB_DEPTH; i++) begin
      idx = head_q + PW'(i);
      if ((CW'(i) < occ) && (ent_addr[idx] == ld_addr)) begin
        ld_data = merge_bytes(ld_data, ent_data[idx], ent_be[idx]);
        ld_hit  = 1'b1;
      end
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(SB_DEPTH)); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !do_commit && !do_rollback) |=> n_pend_q == $past(n_pend_q)); // R9
  AST_RB_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    do_rollback |=> n_pend_q == '0); // R7
  AST_RB_KEEPS_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rollback && !drain_fire) |=> n_rel_q == $past(n_rel_q)); // R8
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !do_rollback) |=>
      mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)); // R8
  AST_HELD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && !do_commit) |=> !mem_valid); // R4
endmodule

// File: rtl/spec_state_unit.sv
module spec_state_unit
  import ssu_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 16,
  parameter int SB_DEPTH = 4,
  localparam int RIW = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RIW-1:0]     rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [RIW-1:0]     wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_low8,
  input  logic               st_valid,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [DATA_W-1:0]  st_data,
  input  logic [BYTES_W-1:0] st_be,
  output logic               sb_full,
  output logic               st_err,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0]  ld_mem_data,
  output logic               ld_hit,
  output logic [DATA_W-1:0]  ld_data,
  input  logic               commit,
  input  logic               rollback,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_data,
  output logic [BYTES_W-1:0] mem_be
);
  // Rollback takes priority over commit
  logic do_commit, do_rollback;
  assign do_rollback = rollback;
  assign do_commit   = commit && !rollback;

  ssu_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk, .rst_n, .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_data, .wr_low8,
    .do_commit, .do_rollback
  );

  ssu_store_buf #(.ADDR_W(ADDR_W), .SB_DEPTH(SB_DEPTH)) u_sb (
    .clk, .rst_n, .st_valid, .st_addr, .st_data, .st_be, .sb_full, .st_err,
    .ld_addr, .ld_mem_data, .ld_hit, .ld_data, .do_commit, .do_rollback,
    .mem_valid, .mem_ready, .mem_addr, .mem_data, .mem_be
  );

  AST_BOTH_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rollback && !mem_valid) |=> !mem_valid); // R10
endmodule

// File: tb/spec_state_unit_tb_top.sv
`timescale 1ns/1ps
module spec_state_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data, st_data, ld_mem_data, ld_data, mem_data;
  logic        wr_en, wr_low8, st_valid, sb_full, st_err, ld_hit;
  logic [15:0] st_addr, ld_addr, mem_addr;
  logic [3:0]  st_be, mem_be;
  logic        commit, rollback, mem_valid, mem_ready;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spec_state_unit dut_i (
    .clk, .rst_n, .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_data, .wr_low8,
    .st_valid, .st_addr, .st_data, .st_be, .sb_full, .st_err,
    .ld_addr, .ld_mem_data, .ld_hit, .ld_data, .commit, .rollback,
    .mem_valid, .mem_ready, .mem_addr, .mem_data, .mem_be
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_en = 0; wr_low8 = 0; st_valid = 0; commit = 0; rollback = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic write(input logic [2:0] a, input logic [31:0] d, input bit low8);
    wr_en = 1; wr_addr = a; wr_data = d; wr_low8 = low8;
    tick();
    idle();
  endtask

  task automatic enq(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    tick();
    idle();
  endtask

  task automatic snoop(input logic [15:0] a, input logic [31:0] md, input bit exp_hit,
                       input logic [31:0] exp_d, input string req);
    ld_addr = a; ld_mem_data = md;
    #1;
    chk(ld_hit == exp_hit, req, 32'(ld_hit), 32'(exp_hit));
    chk(ld_data == exp_d, req, ld_data, exp_d);
  endtask

  task automatic t_reset();
    rd_chk(3'd0, 32'h0, "R1");
    rd_chk(3'd7, 32'h0, "R1");
    chk(!mem_valid && !sb_full, "R1", {30'b0, mem_valid, sb_full}, 32'h0);
    snoop(16'h0000, 32'h12345678, 0, 32'h12345678, "R1");
  endtask

  task automatic t_writes();
    write(3'd3, 32'hDEADBEEF, 0);
    rd_chk(3'd3, 32'hDEADBEEF, "R2");
    write(3'd5, 32'h11223344, 0);
    write(3'd5, 32'hFFFFFF5A, 1);
    rd_chk(3'd5, 32'h1122335A, "R3");
    // shadow still zero: rollback exposes it
    rollback = 1; tick(); idle();
    rd_chk(3'd3, 32'h0, "R2");
  endtask

  task automatic t_commit_rollback();
    write(3'd3, 32'hDEADBEEF, 0);
    wr_en = 1; wr_addr = 3'd2; wr_data = 32'hCAFE0001; wr_low8 = 0; commit = 1;
    tick(); idle();
    write(3'd3, 32'h0BADF00D, 0);
    write(3'd2, 32'h00000000, 0);
    rd_chk(3'd3, 32'h0BADF00D, "R2");
    wr_en = 1; wr_addr = 3'd1; wr_data = 32'h77; rollback = 1;
    tick(); idle();
    rd_chk(3'd3, 32'hDEADBEEF, "R7");
    rd_chk(3'd2, 32'hCAFE0001, "R6");
    rd_chk(3'd1, 32'h0, "R7");
  endtask

  task automatic t_both();
    write(3'd4, 32'h00001234, 0);
    st_valid = 1; st_addr = 16'h0400; st_data = 32'h1; st_be = 4'hF;
    commit = 1; rollback = 1;
    tick(); idle();
    rd_chk(3'd4, 32'h0, "R10");
    chk(!mem_valid, "R10", 32'(mem_valid), 32'h0);
    snoop(16'h0400, 32'h0, 0, 32'h0, "R10");
  endtask

  task automatic t_stores();
    mem_ready = 0;
    enq(16'h0100, 32'h11111111, 4'hF);
    enq(16'h0100, 32'h000000AB, 4'b0001);
    enq(16'h0104, 32'h22222222, 4'hF);
    tick();
    chk(!mem_valid, "R4", 32'(mem_valid), 32'h0);
    snoop(16'h0100, 32'hFFFFFFFF, 1, 32'h111111AB, "R5");
    snoop(16'h0101, 32'hFFFFFFFF, 0, 32'hFFFFFFFF, "R5");
    commit = 1; tick(); idle();
    chk(mem_valid && mem_addr == 16'h0100 && mem_data == 32'h11111111, "R6",
        {mem_addr, mem_data[15:0]}, 32'h01001111);
    tick(); tick();
    chk(mem_valid && mem_addr == 16'h0100 && mem_data == 32'h11111111, "R8",
        {mem_addr, mem_data[15:0]}, 32'h01001111);
    enq(16'h0200, 32'h33333333, 4'hF);
    snoop(16'h0200, 32'h0, 1, 32'h33333333, "R5");
    rollback = 1; tick(); idle();
    snoop(16'h0200, 32'h0, 0, 32'h0, "R7");
    snoop(16'h0104, 32'h0, 1, 32'h22222222, "R8");
    mem_ready = 1;
    chk(mem_valid && mem_addr == 16'h0100 && mem_data == 32'h11111111, "R8",
        {mem_addr, mem_data[15:0]}, 32'h01001111);
    tick();
    chk(mem_valid && mem_addr == 16'h0100 && mem_data == 32'h000000AB && mem_be == 4'b0001,
        "R8", mem_data, 32'h000000AB);
    tick();
    chk(mem_valid && mem_addr == 16'h0104 && mem_data == 32'h22222222, "R8",
        mem_data, 32'h22222222);
    tick();
    chk(!mem_valid, "R8", 32'(mem_valid), 32'h0);
    mem_ready = 0;
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) enq(16'h0300 + 16'(4*i), 32'hA0 + 32'(i), 4'hF);
    chk(sb_full, "R9", 32'(sb_full), 32'h1);
    st_valid = 1; st_addr = 16'h0310; st_data = 32'hBAD; st_be = 4'hF;
    #1;
    chk(st_err, "R9", 32'(st_err), 32'h1);
    tick(); idle();
    snoop(16'h0310, 32'h0, 0, 32'h0, "R9");
    commit = 1; tick(); idle();
    chk(sb_full && mem_valid, "R9", {30'b0, sb_full, mem_valid}, 32'h3);
    mem_ready = 1; tick();
    chk(!sb_full && mem_addr == 16'h0304, "R9", 32'(mem_addr), 32'h0304);
    tick(); tick(); tick();
    chk(!mem_valid, "R8", 32'(mem_valid), 32'h0);
    mem_ready = 0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); mem_ready = 0;
    rd_addr = 0; wr_addr = 0; wr_data = 0; st_addr = 0; st_data = 0; st_be = 0;
    ld_addr = 0; ld_mem_data = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_writes();
    t_commit_rollback();
    t_both();
    t_stores();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule